// File: doc/BRIEF.md
# Shader Condition and Select Unit

This unit decides the 4-bit condition of a shader instruction on four-lane FP32 vectors. For a SET instruction it writes 1.0 or 0.0 into each destination lane. For a SELECT instruction it picks, lane by lane, one of two source operands. For a conditional branch or a fragment kill it raises a single taken flag. The execution pipe drives one instruction per cycle with `in_valid` high. One clock edge later the unit registers the results.

The sixteen condition codes fall into three kinds:
- ordered FP comparisons;
- logical tests that treat any nonzero lane as true;
- unary sign tests on `src0`.

A SELECT with a binary condition compares `src1` against `src0`. A unary condition tests `src0` and chooses the opposite pair of operands. With the operands (a, b, a), this lets one instruction form a lane-wise minimum or maximum. The destination holds its previous contents in every lane that the write mask leaves out.

Top module: `shd_cond_unit`

## Requirements
- R1: While reset is asserted and after it is released, `dst` is all zero, `dst_we` is 0 and `taken` is 0.
- R2: SET (`op_class`=0) writes 0x3F800000 (1.0) to a lane when `src0 COND src1` holds and 0x00000000 otherwise, one cycle after issue. The compare codes are GT=1, LT=2, GE=3, LE=4, EQ=5 and NE=6. Lane i occupies bits [32i+31:32i], with x as lane 0.
- R3: Comparisons use IEEE-754 order. +0 equals -0. A NaN operand makes every comparison false except NE, which is true.
- R4: The logical codes AND=7, OR=8 and XOR=9 combine the "nonzero" truth of the two operands. ±0 is false, and NaN counts as nonzero.
- R5: The unary codes look only at `src0`: NOT=10 (is zero), NZ=11 (nonzero), GEZ=12, GZ=13, LEZ=14 and LZ=15. The sign tests are false for NaN, and -0 counts as zero. TRUE=0 always holds.
- R6: SELECT (`op_class`=1) with a binary code (1 to 9) gives `src2` where `src1 COND src0` holds and `src1` elsewhere. With operands (a, b, a), GT yields min(a,b) and LT yields max(a,b).
- R7: SELECT with a unary code (0 or 10 to 15) gives `src1` where COND(`src0`) holds and `src2` elsewhere.
- R8: BRANCH (2) and KILL (3) raise `taken` one cycle later when `src0.x COND src1.x` holds, and always for TRUE. Lanes y to w are ignored. These ops write no lane and leave `dst` unchanged.
- R9: For SET and SELECT, `dst_we` equals `wr_mask` (bit 0 = x to bit 3 = w). Lanes whose mask bit is clear keep their previous value.
- R10: With `sat_en` set, each SET or SELECT result is clamped. Negative values, -0 and NaN become +0.0. Values above 1.0, including +inf, become 1.0.
- R11: A cycle with `in_valid` low leaves `dst` unchanged and gives `dst_we`=0 and `taken`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Instruction issued this cycle |
| op_class | input | 2 | 0 SET, 1 SELECT, 2 BRANCH, 3 KILL |
| cond_code | input | 4 | Condition code 0 to 15 |
| src0 | input | 128 | Source vector 0, lane x in bits 31:0 |
| src1 | input | 128 | Source vector 1 |
| src2 | input | 128 | Source vector 2 |
| wr_mask | input | 4 | Destination lane mask, bit 0 = x |
| sat_en | input | 1 | Clamp SET/SELECT results to [0,1] |
| dst | output | 128 | Registered destination vector |
| dst_we | output | 4 | Lanes written by the last issued instruction |
| taken | output | 1 | Branch/kill decision of the last issued instruction |

## Verification
SET is driven with vectors whose lanes are less than, equal to and greater than each other, and with negative operands. These tell a correct magnitude order from a wrong one and show that each of the six compare codes is distinct. Signed zeros and NaN lanes separate IEEE ordering from raw bit comparison. Zero, -0 and NaN lanes separate the logical and sign tests, and an all-NaN `src1` shows that the unary tests ignore it. SELECT runs with (a, b, a) operands and with three distinct operands, which exposes a swapped operand role. Branches are driven with opposite outcomes in x and in the other lanes, which proves that only x decides.

// File: rtl/shd_cond_pkg.sv
package shd_cond_pkg;

  localparam int FP_W      = 32;
  localparam int FP_MANT_W = 23;
  localparam int CODE_W    = 4;

  localparam logic [FP_W-1:0] FP_ZERO = 32'h0000_0000;
  localparam logic [FP_W-1:0] FP_ONE  = 32'h3F80_0000;

  typedef enum logic [1:0] {
    OP_SET    = 2'd0,
    OP_SELECT = 2'd1,
    OP_BRANCH = 2'd2,
    OP_KILL   = 2'd3
  } op_class_e;

  // encoding is fixed: the instruction decoder feeds the raw field
  typedef enum logic [CODE_W-1:0] {
    CC_TRUE = 4'd0,  CC_GT  = 4'd1,  CC_LT  = 4'd2,  CC_GE  = 4'd3,
    CC_LE   = 4'd4,  CC_EQ  = 4'd5,  CC_NE  = 4'd6,  CC_AND = 4'd7,
    CC_OR   = 4'd8,  CC_XOR = 4'd9,  CC_NOT = 4'd10, CC_NZ  = 4'd11,
    CC_GEZ  = 4'd12, CC_GZ  = 4'd13, CC_LEZ = 4'd14, CC_LZ  = 4'd15
  } cond_e;

  // relation of operand a to operand b, plus single-operand facts about a
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic a_zero;
    logic b_zero;
    logic a_neg;
    logic a_nan;
  } fp_rel_t;

  function automatic logic cond_is_binary(input logic [CODE_W-1:0] c);
    return (c >= CC_GT) && (c <= CC_XOR);
  endfunction

endpackage

// File: rtl/shd_fcmp.sv
module shd_fcmp
  import shd_cond_pkg::*;
(
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  output fp_rel_t         rel_o
);

  localparam int SIGN_B = FP_W - 1;
  localparam int MAG_HI = FP_W - 2;

  logic a_nan, b_nan, unord;
  logic a_zero, b_zero, both_zero;
  logic a_neg, b_neg;
  logic a_mag_lt, b_mag_lt;
  logic lt_raw, gt_raw, eq_raw;

  always_comb begin
    a_nan     = (&a_i[MAG_HI:FP_MANT_W]) & (|a_i[FP_MANT_W-1:0]);
    b_nan     = (&b_i[MAG_HI:FP_MANT_W]) & (|b_i[FP_MANT_W-1:0]);
    unord     = a_nan | b_nan;
    a_zero    = ~|a_i[MAG_HI:0];
    b_zero    = ~|b_i[MAG_HI:0];
    both_zero = a_zero & b_zero;
    a_neg     = a_i[SIGN_B];
    b_neg     = b_i[SIGN_B];
    a_mag_lt  = a_i[MAG_HI:0] < b_i[MAG_HI:0];
    b_mag_lt  = b_i[MAG_HI:0] < a_i[MAG_HI:0];

    if (both_zero) begin
      lt_raw = 1'b0;
      gt_raw = 1'b0;
    end else if (a_neg != b_neg) begin
      lt_raw = a_neg;
      gt_raw = b_neg;
    end else if (!a_neg) begin
      lt_raw = a_mag_lt;
      gt_raw = b_mag_lt;
    end else begin
      lt_raw = b_mag_lt;
      gt_raw = a_mag_lt;
    end
    eq_raw = both_zero | (a_i == b_i);

    rel_o.lt     = lt_raw & ~unord;
    rel_o.gt     = gt_raw & ~unord;
    rel_o.eq     = eq_raw & ~unord;
    rel_o.a_zero = a_zero;
    rel_o.b_zero = b_zero;
    rel_o.a_neg  = a_neg;
    rel_o.a_nan  = a_nan;
  end

endmodule

// File: rtl/shd_cond_eval.sv
module shd_cond_eval
  import shd_cond_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  fp_rel_t           rel_i,
  output logic              hit_o
);

  cond_e code;
  logic  a_true, b_true, sign_ok;

  always_comb begin
    code    = cond_e'(code_i);
    a_true  = ~rel_i.a_zero;
    b_true  = ~rel_i.b_zero;
    sign_ok = ~rel_i.a_nan;
    case (code)
      CC_TRUE: hit_o = 1'b1;
      CC_GT:   hit_o = rel_i.gt;
      CC_LT:   hit_o = rel_i.lt;
      CC_GE:   hit_o = rel_i.gt | rel_i.eq;
      CC_LE:   hit_o = rel_i.lt | rel_i.eq;
      CC_EQ:   hit_o = rel_i.eq;
      CC_NE:   hit_o = ~rel_i.eq;
      CC_AND:  hit_o = a_true & b_true;
      CC_OR:   hit_o = a_true | b_true;
      CC_XOR:  hit_o = a_true ^ b_true;
      CC_NOT:  hit_o = rel_i.a_zero;
      CC_NZ:   hit_o = a_true;
      CC_GEZ:  hit_o = sign_ok & (~rel_i.a_neg | rel_i.a_zero);
      CC_GZ:   hit_o = sign_ok & ~rel_i.a_neg & ~rel_i.a_zero;
      CC_LEZ:  hit_o = sign_ok & (rel_i.a_neg | rel_i.a_zero);
      CC_LZ:   hit_o = sign_ok & rel_i.a_neg & ~rel_i.a_zero;
      default: hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/shd_clamp.sv
module shd_clamp
  import shd_cond_pkg::*;
(
  input  logic            en_i,
  input  logic [FP_W-1:0] val_i,
  output logic [FP_W-1:0] val_o
);

  localparam int MAG_HI = FP_W - 2;

  logic is_nan, is_neg, above_one;

  always_comb begin
    is_nan    = (&val_i[MAG_HI:FP_MANT_W]) & (|val_i[FP_MANT_W-1:0]);
    is_neg    = val_i[FP_W-1];
    above_one = val_i[MAG_HI:0] > FP_ONE[MAG_HI:0];
    if (!en_i)                 val_o = val_i;
    else if (is_nan || is_neg) val_o = FP_ZERO;
    else if (above_one)        val_o = FP_ONE;
    else                       val_o = val_i;
  end

endmodule

// File: rtl/shd_cond_lane.sv
module shd_cond_lane
  import shd_cond_pkg::*;
(
  input  op_class_e         op_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [FP_W-1:0]   s0_i,
  input  logic [FP_W-1:0]   s1_i,
  input  logic [FP_W-1:0]   s2_i,
  input  logic              sat_i,
  output logic              hit_o,
  output logic [FP_W-1:0]   res_o
);

  logic            binary, swap;
  logic [FP_W-1:0] cmp_a, cmp_b, raw;
  fp_rel_t         rel;

  // a single comparator; SELECT with a binary code reverses the operand roles
  always_comb begin
    binary = cond_is_binary(code_i);
    swap   = (op_i == OP_SELECT) && binary;
    cmp_a  = swap ? s1_i : s0_i;
    cmp_b  = swap ? s0_i : s1_i;
  end

  shd_fcmp u_cmp (
    .a_i   (cmp_a),
    .b_i   (cmp_b),
    .rel_o (rel)
  );

  shd_cond_eval u_eval (
    .code_i (code_i),
    .rel_i  (rel),
    .hit_o  (hit_o)
  );

  always_comb begin
    if (op_i == OP_SELECT) begin
      if (binary) raw = hit_o ? s2_i : s1_i;
      else        raw = hit_o ? s1_i : s2_i;
    end else begin
      raw = hit_o ? FP_ONE : FP_ZERO;
    end
  end

  shd_clamp u_sat (
    .en_i  (sat_i),
    .val_i (raw),
    .val_o (res_o)
  );

endmodule

// File: rtl/shd_cond_unit.sv
module shd_cond_unit
  import shd_cond_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            op_class,
  input  logic [CODE_W-1:0]     cond_code,
  input  logic [LANES*FP_W-1:0] src0,
  input  logic [LANES*FP_W-1:0] src1,
  input  logic [LANES*FP_W-1:0] src2,
  input  logic [LANES-1:0]      wr_mask,
  input  logic                  sat_en,
  output logic [LANES*FP_W-1:0] dst,
  output logic [LANES-1:0]      dst_we,
  output logic                  taken
);

  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[SYNC_STAGES-1];

  op_class_e                    op;
  logic                         is_flow;
  logic [LANES-1:0]             hit;
  logic [LANES-1:0][FP_W-1:0]   res;
  logic [LANES-1:0][FP_W-1:0]   dst_q;
  logic [LANES-1:0]             we_d, we_q;
  logic                         taken_d, taken_q;

  assign op      = op_class_e'(op_class);
  assign is_flow = (op == OP_BRANCH) || (op == OP_KILL);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    shd_cond_lane u_lane (
      .op_i   (op),
      .code_i (cond_code),
      .s0_i   (src0[g*FP_W +: FP_W]),
      .s1_i   (src1[g*FP_W +: FP_W]),
      .s2_i   (src2[g*FP_W +: FP_W]),
      .sat_i  (sat_en),
      .hit_o  (hit[g]),
      .res_o  (res[g])
    );
  end

  // next state
  always_comb begin
    we_d    = (in_valid && !is_flow) ? wr_mask : '0;
    taken_d = in_valid && is_flow && hit[0];
  end

  // registers: per-lane clock enable on the destination
  for (genvar g = 0; g < LANES; g++) begin : g_dst
    always_ff @(posedge clk or negedge rst_in_n) begin
      if (!rst_in_n)   dst_q[g] <= '0;
      else if (we_d[g]) dst_q[g] <= res[g];
    end
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      we_q    <= '0;
      taken_q <= 1'b0;
    end else begin
      we_q    <= we_d;
      taken_q <= taken_d;
    end
  end

  assign dst    = dst_q;
  assign dst_we = we_q;
  assign taken  = taken_q;

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    !in_valid |=> (dst_we == '0) && !taken && $stable(dst));

  // R9
  mask_to_we_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    (in_valid && !op_class[1]) |=> (dst_we == $past(wr_mask)) && !taken);

  // R8
  flow_no_write_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    (in_valid && op_class[1]) |=> (dst_we == '0) && $stable(dst));

  // R8
  flow_true_taken_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    (in_valid && op_class[1] && cond_code == CC_TRUE) |=> taken);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R2
    set_is_bool_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
      (in_valid && op_class == OP_SET && wr_mask[g]) |=>
        (dst[g*FP_W +: FP_W] == FP_ZERO) || (dst[g*FP_W +: FP_W] == FP_ONE));

    // R10
    sat_range_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
      (in_valid && !op_class[1] && sat_en && wr_mask[g]) |=>
        !dst[g*FP_W + FP_W - 1] && (dst[g*FP_W +: FP_W-1] <= FP_ONE[FP_W-2:0]));
  end

endmodule

// File: tb/sim_shd_cond_unit.sv
module sim_shd_cond_unit;

  localparam logic [31:0] F0   = 32'h0000_0000, FN0 = 32'h8000_0000;
  localparam logic [31:0] F1   = 32'h3F80_0000, FM1 = 32'hBF80_0000;
  localparam logic [31:0] F2   = 32'h4000_0000;
  localparam logic [31:0] F3   = 32'h4040_0000, FM3 = 32'hC040_0000;
  localparam logic [31:0] F4   = 32'h4080_0000, F5  = 32'h40A0_0000;
  localparam logic [31:0] FH   = 32'h3F00_0000, FNAN = 32'h7FC0_0000;
  localparam logic [31:0] FINF = 32'h7F80_0000;
  localparam logic [31:0] FM2  = 32'hC000_0000;
  localparam logic [31:0] FJUST = 32'h3F80_0001;

  localparam logic [1:0] SET = 2'd0, SEL = 2'd1, BR = 2'd2, KILL = 2'd3;
  localparam logic [3:0] TRU = 4'd0, GT = 4'd1, LT = 4'd2, GE = 4'd3, LE = 4'd4,
                         EQ = 4'd5, NE = 4'd6, AND_ = 4'd7, OR_ = 4'd8, XOR_ = 4'd9,
                         NOT_ = 4'd10, NZ = 4'd11, GEZ = 4'd12, GZ = 4'd13,
                         LEZ = 4'd14, LZ = 4'd15;

  logic         clk = 1'b0;
  logic         rst_n, in_valid, sat_en;
  logic [1:0]   op_class;
  logic [3:0]   cond_code, wr_mask;
  logic [127:0] src0, src1, src2, dst;
  logic [3:0]   dst_we;
  logic         taken;
  int           n_chk = 0, n_bad = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  shd_cond_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
    .cond_code(cond_code), .src0(src0), .src1(src1), .src2(src2),
    .wr_mask(wr_mask), .sat_en(sat_en), .dst(dst), .dst_we(dst_we), .taken(taken)
  );

  function automatic logic [127:0] v4(input logic [31:0] x, y, z, w);
    return {w, z, y, x};
  endfunction

  function automatic logic [127:0] bv(input logic [3:0] b);
    return v4(b[0] ? F1 : F0, b[1] ? F1 : F0, b[2] ? F1 : F0, b[3] ? F1 : F0);
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // issue one instruction; on return the registered results are visible
  task automatic issue(input logic [1:0] op, input logic [3:0] cc,
                       input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                       input logic [3:0] m, input logic s);
    @(negedge clk);
    op_class = op; cond_code = cc; src0 = a; src1 = b; src2 = c;
    wr_mask = m; sat_en = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 dst", dst, '0);
    chk("R1 dst_we", {124'd0, dst_we}, '0);
    chk("R1 taken", {127'd0, taken}, '0);
  endtask

  task automatic t_compare();
    logic [127:0] a = v4(F1, F2, FM1, F2), b = v4(F2, F2, FM2, F1);
    issue(SET, GT, a, b, '0, 4'hF, 0); chk("R2 GT", dst, bv(4'b1100));
    chk("R2 we", {124'd0, dst_we}, 128'hF);
    issue(SET, LT, a, b, '0, 4'hF, 0); chk("R2 LT", dst, bv(4'b0001));
    issue(SET, GE, a, b, '0, 4'hF, 0); chk("R2 GE", dst, bv(4'b1110));
    issue(SET, LE, a, b, '0, 4'hF, 0); chk("R2 LE", dst, bv(4'b0011));
    issue(SET, EQ, a, b, '0, 4'hF, 0); chk("R2 EQ", dst, bv(4'b0010));
    issue(SET, NE, a, b, '0, 4'hF, 0); chk("R2 NE", dst, bv(4'b1101));
  endtask

  task automatic t_ieee();
    logic [127:0] a = v4(F0, FNAN, FM1, F1), b = v4(FN0, F1, FNAN, FM1);
    issue(SET, EQ, a, b, '0, 4'hF, 0); chk("R3 EQ zeros/NaN", dst, bv(4'b0001));
    issue(SET, NE, a, b, '0, 4'hF, 0); chk("R3 NE NaN", dst, bv(4'b1110));
    issue(SET, GE, a, b, '0, 4'hF, 0); chk("R3 GE", dst, bv(4'b1001));
    issue(SET, LT, a, b, '0, 4'hF, 0); chk("R3 LT", dst, bv(4'b0000));
    issue(SET, GT, a, b, '0, 4'hF, 0); chk("R3 GT", dst, bv(4'b1000));
  endtask

  task automatic t_logic();
    logic [127:0] a = v4(F0, F2, FN0, FNAN), b = v4(F3, F0, FN0, F1);
    issue(SET, AND_, a, b, '0, 4'hF, 0); chk("R4 AND", dst, bv(4'b1000));
    issue(SET, OR_,  a, b, '0, 4'hF, 0); chk("R4 OR",  dst, bv(4'b1011));
    issue(SET, XOR_, a, b, '0, 4'hF, 0); chk("R4 XOR", dst, bv(4'b0011));
  endtask

  task automatic t_unary();
    logic [127:0] a = v4(FM1, F0, FN0, F2), b = v4(FNAN, FNAN, FNAN, FNAN);
    issue(SET, NOT_, a, b, '0, 4'hF, 0); chk("R5 NOT", dst, bv(4'b0110));
    issue(SET, NZ,   a, b, '0, 4'hF, 0); chk("R5 NZ",  dst, bv(4'b1001));
    issue(SET, GEZ,  a, b, '0, 4'hF, 0); chk("R5 GEZ", dst, bv(4'b1110));
    issue(SET, GZ,   a, b, '0, 4'hF, 0); chk("R5 GZ",  dst, bv(4'b1000));
    issue(SET, LEZ,  a, b, '0, 4'hF, 0); chk("R5 LEZ", dst, bv(4'b0111));
    issue(SET, LZ,   a, b, '0, 4'hF, 0); chk("R5 LZ",  dst, bv(4'b0001));
    issue(SET, TRU,  a, b, '0, 4'hF, 0); chk("R5 TRUE", dst, bv(4'b1111));
    issue(SET, GZ, v4(FNAN, FNAN, FNAN, FNAN), b, '0, 4'hF, 0);
    chk("R5 GZ NaN", dst, bv(4'b0000));
  endtask

  task automatic t_select_binary();
    logic [127:0] a = v4(F1, F5, FM3, F2), b = v4(F4, F2, FM1, F2);
    issue(SEL, GT, a, b, a, 4'hF, 0); chk("R6 min", dst, v4(F1, F2, FM3, F2));
    issue(SEL, LT, a, b, a, 4'hF, 0); chk("R6 max", dst, v4(F4, F5, FM1, F2));
    issue(SEL, GT, v4(F1, F1, F1, F1), v4(F2, F2, F2, F2), v4(F3, F3, F3, F3), 4'hF, 0);
    chk("R6 operand roles", dst, v4(F3, F3, F3, F3));
  endtask

  task automatic t_select_unary();
    logic [127:0] a = v4(F1, FM1, F0, FNAN), b = v4(F2, F2, F2, F2), c = v4(FH, FH, FH, FH);
    issue(SEL, GZ,   a, b, c, 4'hF, 0); chk("R7 GZ",   dst, v4(F2, FH, FH, FH));
    issue(SEL, NOT_, a, b, c, 4'hF, 0); chk("R7 NOT",  dst, v4(FH, FH, F2, FH));
    issue(SEL, TRU,  a, b, c, 4'hF, 0); chk("R7 TRUE", dst, b);
  endtask

  task automatic t_branch();
    issue(SET, TRU, '0, '0, '0, 4'hF, 0); chk("R8 preload", dst, bv(4'hF));
    issue(BR, GT, v4(F2, F0, F0, F0), v4(F1, F3, F3, F3), '0, 4'hF, 0);
    chk("R8 x taken", {127'd0, taken}, 128'd1);
    chk("R8 no we", {124'd0, dst_we}, '0);
    chk("R8 dst kept", dst, bv(4'hF));
    issue(BR, GT, v4(F1, F5, F5, F5), v4(F2, F1, F1, F1), '0, 4'hF, 0);
    chk("R8 x not taken", {127'd0, taken}, '0);
    issue(KILL, TRU, v4(FNAN, FNAN, FNAN, FNAN), '0, '0, 4'hF, 0);
    chk("R8 TRUE kill", {127'd0, taken}, 128'd1);
    issue(KILL, LT, v4(F1, F0, F0, F0), v4(F2, F0, F0, F0), '0, 4'hF, 0);
    chk("R8 kill order", {127'd0, taken}, 128'd1);
    chk("R8 kill dst kept", dst, bv(4'hF));
  endtask

  task automatic t_mask();
    issue(SEL, TRU, '0, v4(F2, F3, F4, F5), '0, 4'b0101, 0);
    chk("R9 we", {124'd0, dst_we}, 128'h5);
    chk("R9 partial", dst, v4(F2, F1, F4, F1));
    issue(SET, TRU, '0, '0, '0, 4'b0000, 0);
    chk("R9 empty mask", dst, v4(F2, F1, F4, F1));
    chk("R9 empty we", {124'd0, dst_we}, '0);
  endtask

  task automatic t_sat();
    issue(SEL, TRU, '0, v4(FM1, F2, FH, FNAN), '0, 4'hF, 1);
    chk("R10 clamp a", dst, v4(F0, F1, FH, F0));
    issue(SEL, TRU, '0, v4(FN0, FINF, F1, FJUST), '0, 4'hF, 1);
    chk("R10 clamp b", dst, v4(F0, F1, F1, F1));
    issue(SEL, TRU, '0, v4(FM1, F2, FH, FNAN), '0, 4'hF, 0);
    chk("R10 off", dst, v4(FM1, F2, FH, FNAN));
  endtask

  task automatic t_idle();
    @(negedge clk);
    op_class = SET; cond_code = TRU; wr_mask = 4'hF; sat_en = 0; in_valid = 1'b0;
    @(negedge clk);
    chk("R11 dst held", dst, v4(FM1, F2, FH, FNAN));
    chk("R11 no we", {124'd0, dst_we}, '0);
    chk("R11 no taken", {127'd0, taken}, '0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_class = '0; cond_code = '0;
    src0 = '0; src1 = '0; src2 = '0; wr_mask = '0; sat_en = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_compare();
    t_ieee();
    t_logic();
    t_unary();
    t_select_binary();
    t_select_unary();
    t_branch();
    t_mask();
    t_sat();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule